// File: doc/BRIEF.md
# I2C stuck-bus recovery controller

This controller sits beside a two-channel I2C buffer or multiplexer. It decides when each downstream channel may be joined to the upstream side, watches the shared downstream node for a bus that stays low, and tries to free such a bus. It does not do the analog buffering. It works only on sampled logic levels, and every time interval is a clock-cycle parameter.

After reset, after power-good rises, and after any edge of the secondary-supply flag, the block holds a lockout for a set number of cycles. During lockout no channel is connected and the bus and enable inputs are ignored. Outside lockout each enable joins its channel directly. While any channel is joined, a timer measures how long SCL and SDA have gone without being high together in the same sample. When that time reaches the limit, FAULT is raised.

A strap input chooses what happens next. With the strap low, the block only reports the fault. With the strap high, it drops every connection and waits. It then drives open-drain pulldowns that clock SCL until the bus frees itself or the pulse limit is reached, and it ends with a stop condition. FAULT stays set until the bus has been seen high and both enables have been seen low. Only a later enable assertion joins a channel again.

Top module: `busclear_ctrl`

## Requirements
- R1: While power-good is low, and for LOCK_CYC cycles after it rises, both connects are 0, FAULT is 0, and the enables and bus levels have no effect.
- R2: An edge of the secondary-supply flag, rising or falling, restarts the LOCK_CYC lockout with the same effect as R1.
- R3: Outside lockout and with no fault pending, connect bit c equals enable bit c, and both channels may be connected at the same time.
- R4: While at least one channel is connected, FAULT rises once STUCK_CYC consecutive synchronized samples have passed without SCL and SDA both high. A sample with both high restarts the count. Nothing is counted while no channel is connected.
- R5: With the strap high, FAULT rising drops every connect to 0 in the same cycle.
- R6: With the strap high, the SCL pulldown stays off for WAIT_CYC cycles after the fault. It then makes up to NPULSE pulses, each HALF_CYC cycles pulled (pulldown = 1) followed by HALF_CYC cycles released. A stop follows: SDA is pulled while SCL is pulled, SCL is released, and then SDA is released while SCL stays released.
- R7: If SCL and SDA are both high at the end of a released half-period, no further pulse is issued and the stop follows at once.
- R8: With the strap low, a fault only raises FAULT: connects keep following the enables and neither pulldown turns on.
- R9: FAULT clears only after the bus has been seen with both lines high and both enables low. A channel is connected again only when its enable is asserted after that.
- R10: If the bus is already stuck when power comes up, the enabled channels connect when lockout ends and FAULT rises after the timeout.
- R11: Neither pulldown is active while channels are connected or while the block is locked out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Main supply good |
| vsec_hi | input | 1 | Secondary supply above its threshold |
| chan_en | input | NCH | Per-channel enable requests |
| discon_en | input | 1 | Strap: 1 = disconnect and attempt recovery on a fault |
| scl_in | input | 1 | Raw SCL level at the common downstream node |
| sda_in | input | 1 | Raw SDA level at the common downstream node |
| chan_conn | output | NCH | Per-channel connect controls |
| fault | output | 1 | Stuck-bus fault flag |
| scl_pd | output | 1 | Downstream SCL open-drain pulldown, 1 = pull low |
| sda_pd | output | 1 | Downstream SDA open-drain pulldown, 1 = pull low |

## Verification
The assertions check on every cycle that lockout follows power-good low and every supply-flag edge, and that FAULT is cleared while locked out. They also check that the pulldowns stay off while a link is up, that the pulse index stays below the limit, that SDA is released only while SCL is released, that a strap-high fault leaves no channel connected, and that FAULT falls only after both enables were low. Some behaviour shows only in the bench's scenarios: the exact length of the stuck-bus timeout, the count restarting on a high sample, the number of pulses with and without an early bus release, the ordering of the reconnect rule, and a power-up into a bus that is already stuck.

// File: rtl/busclear_pkg.sv
// Shared types for the stuck-bus recovery controller.
package busclear_pkg;
    typedef enum logic [2:0] {
        ST_RUN,   // normal linking and monitoring
        ST_HOLD,  // fault flagged, strap low, links kept
        ST_WAIT,  // links dropped, quiet wait before pulses
        ST_LOW,   // SCL pulled for a half period
        ST_HIGH,  // SCL released for a half period
        ST_STP1,  // SCL and SDA pulled
        ST_STP2,  // SCL released, SDA still pulled
        ST_DONE   // stop issued, waiting for clear
    } rec_state_t;
endpackage

// File: rtl/bc_sync2.sv
// Two-flop synchronizer for asynchronous level inputs.
// Assumes the inputs are slow relative to clk; adds two cycles of latency.
module bc_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages toward the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/bc_lockout.sv
// Lockout timer: holds 'locked' while power-good is low and for LOCK_CYC
// cycles after it rises, and restarts the same interval on any edge of the
// secondary-supply flag. Assumes both flags are already clean levels.
module bc_lockout #(
    parameter int LOCK_CYC = 27500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic vsec_hi,
    output logic locked
);
    localparam int CW = $clog2(LOCK_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(LOCK_CYC);

    logic [CW-1:0] cnt;
    logic          vsec_q;

    // Reload on supply loss or supply-flag edge, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= LOAD;
            vsec_q <= 1'b0;
        end else begin
            vsec_q <= vsec_hi;
            if (!pwr_good || (vsec_hi != vsec_q)) begin
                cnt <= LOAD;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign locked = (cnt != '0);

    a_r1_lock_while_down : assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> locked);

    a_r2_lock_on_supply_edge : assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vsec_hi) |=> locked);
endmodule

// File: rtl/bc_recover.sv
// Stuck-bus monitor and recovery sequencer. Joins channels to their enables
// while running, times the absence of a joint SCL/SDA high sample, raises the
// fault, and (strap high) clocks the bus with open-drain pulldowns then issues
// a stop. Assumes scl_s/sda_s are synchronized and HALF_CYC >= 3 so a released
// line is seen through the synchronizer before a half period ends.
module bc_recover
    import busclear_pkg::*;
#(
    parameter int NCH       = 2,
    parameter int STUCK_CYC = 11250000,
    parameter int WAIT_CYC  = 10000,
    parameter int HALF_CYC  = 22727,
    parameter int NPULSE    = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           locked,
    input  logic [NCH-1:0] chan_en,
    input  logic           discon_en,
    input  logic           scl_s,
    input  logic           sda_s,
    output logic [NCH-1:0] chan_conn,
    output logic           fault,
    output logic           scl_pd,
    output logic           sda_pd
);
    localparam int SW   = $clog2(STUCK_CYC + 1);
    localparam int PMAX = (WAIT_CYC > HALF_CYC) ? WAIT_CYC : HALF_CYC;
    localparam int PW   = $clog2(PMAX + 1);
    localparam int NW   = $clog2(NPULSE + 1);
    localparam logic [SW-1:0] STUCK_LAST = SW'(STUCK_CYC - 1);
    localparam logic [PW-1:0] WAIT_LAST  = PW'(WAIT_CYC - 1);
    localparam logic [PW-1:0] HALF_LAST  = PW'(HALF_CYC - 1);
    localparam logic [NW-1:0] NP_LAST    = NW'(NPULSE - 1);

    rec_state_t    state;
    logic [SW-1:0] stuck_cnt;
    logic [PW-1:0] ph_cnt;
    logic [NW-1:0] np_cnt;
    logic          rec_seen;
    logic          both_hi;
    logic          link_on;
    logic          any_conn;
    logic          stuck_hit;

    assign both_hi   = scl_s & sda_s;
    assign link_on   = !locked && (state == ST_RUN || state == ST_HOLD);
    assign any_conn  = |chan_conn;
    assign stuck_hit = (state == ST_RUN) && any_conn && !both_hi && (stuck_cnt == STUCK_LAST);

    // One connect gate per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_link
        assign chan_conn[c] = link_on & chan_en[c];
    end

    // Stuck timer: counts samples without a joint high while a link is up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stuck_cnt <= '0;
        end else if (locked || state != ST_RUN || !any_conn || both_hi) begin
            stuck_cnt <= '0;
        end else if (!stuck_hit) begin
            stuck_cnt <= stuck_cnt + 1'b1;
        end
    end

    // Fault and recovery sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n || locked) begin
            state    <= ST_RUN;
            fault    <= 1'b0;
            scl_pd   <= 1'b0;
            sda_pd   <= 1'b0;
            ph_cnt   <= '0;
            np_cnt   <= '0;
            rec_seen <= 1'b0;
        end else begin
            case (state)
                ST_RUN: begin
                    if (stuck_hit) begin
                        fault    <= 1'b1;
                        rec_seen <= 1'b0;
                        if (discon_en) begin
                            state  <= ST_WAIT;
                            ph_cnt <= WAIT_LAST;
                        end else begin
                            state <= ST_HOLD;
                        end
                    end
                end
                ST_WAIT: begin
                    if (ph_cnt == '0) begin
                        state  <= ST_LOW;
                        scl_pd <= 1'b1;
                        ph_cnt <= HALF_LAST;
                        np_cnt <= '0;
                    end else begin
                        ph_cnt <= ph_cnt - 1'b1;
                    end
                end
                ST_LOW: begin
                    if (ph_cnt == '0) begin
                        state  <= ST_HIGH;
                        scl_pd <= 1'b0;
                        ph_cnt <= HALF_LAST;
                    end else begin
                        ph_cnt <= ph_cnt - 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (ph_cnt == '0) begin
                        scl_pd <= 1'b1;
                        ph_cnt <= HALF_LAST;
                        if (both_hi || np_cnt == NP_LAST) begin
                            state  <= ST_STP1;
                            sda_pd <= 1'b1;
                        end else begin
                            state  <= ST_LOW;
                            np_cnt <= np_cnt + 1'b1;
                        end
                    end else begin
                        ph_cnt <= ph_cnt - 1'b1;
                    end
                end
                ST_STP1: begin
                    if (ph_cnt == '0) begin
                        state  <= ST_STP2;
                        scl_pd <= 1'b0;
                        ph_cnt <= HALF_LAST;
                    end else begin
                        ph_cnt <= ph_cnt - 1'b1;
                    end
                end
                ST_STP2: begin
                    if (ph_cnt == '0) begin
                        state  <= ST_DONE;
                        sda_pd <= 1'b0;
                    end else begin
                        ph_cnt <= ph_cnt - 1'b1;
                    end
                end
                default: begin  // ST_HOLD, ST_DONE: wait for bus high then enables low
                    if (both_hi) rec_seen <= 1'b1;
                    if (rec_seen && chan_en == '0) begin
                        fault <= 1'b0;
                        state <= ST_RUN;
                    end
                end
            endcase
        end
    end

    a_r1_fault_low_locked : assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> !fault);

    a_r5_drop_links : assert property (@(posedge clk) disable iff (!rst_n)
        (stuck_hit && discon_en && !locked) |=> (chan_conn == '0 && fault));

    a_r8_flag_only : assert property (@(posedge clk) disable iff (!rst_n)
        (stuck_hit && !discon_en && !locked) |=> (fault && !scl_pd && !sda_pd));

    a_r6_pulse_bound : assert property (@(posedge clk) disable iff (!rst_n)
        np_cnt <= NP_LAST);

    a_r6_stop_order : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pd) |-> !scl_pd);

    a_r11_quiet_link : assert property (@(posedge clk) disable iff (!rst_n)
        (link_on || $past(locked)) |-> (!scl_pd && !sda_pd));

    a_r9_clear_rule : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> ($past(chan_en) == '0 || $past(locked)));
endmodule

// File: rtl/busclear_ctrl.sv
// Top of the stuck-bus recovery controller: synchronizes the bus levels,
// runs the supply lockout and the monitor/recovery sequencer.
// Assumes pwr_good, vsec_hi, chan_en and discon_en are synchronous to clk.
module busclear_ctrl #(
    parameter int NCH       = 2,
    parameter int LOCK_CYC  = 27500,
    parameter int STUCK_CYC = 11250000,
    parameter int WAIT_CYC  = 10000,
    parameter int HALF_CYC  = 22727,
    parameter int NPULSE    = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_good,
    input  logic           vsec_hi,
    input  logic [NCH-1:0] chan_en,
    input  logic           discon_en,
    input  logic           scl_in,
    input  logic           sda_in,
    output logic [NCH-1:0] chan_conn,
    output logic           fault,
    output logic           scl_pd,
    output logic           sda_pd
);
    logic [1:0] bus_s;
    logic       locked;

    bc_sync2 #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (bus_s)
    );

    bc_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .vsec_hi  (vsec_hi),
        .locked   (locked)
    );

    bc_recover #(
        .NCH       (NCH),
        .STUCK_CYC (STUCK_CYC),
        .WAIT_CYC  (WAIT_CYC),
        .HALF_CYC  (HALF_CYC),
        .NPULSE    (NPULSE)
    ) u_rec (
        .clk       (clk),
        .rst_n     (rst_n),
        .locked    (locked),
        .chan_en   (chan_en),
        .discon_en (discon_en),
        .scl_s     (bus_s[1]),
        .sda_s     (bus_s[0]),
        .chan_conn (chan_conn),
        .fault     (fault),
        .scl_pd    (scl_pd),
        .sda_pd    (sda_pd)
    );
endmodule

// File: tb/sim_busclear_ctrl.sv
// Self-checking bench: directed corner cases plus seeded random enables.
module sim_busclear_ctrl;
    localparam int LOCK  = 50;
    localparam int STUCK = 400;
    localparam int WAITC = 20;
    localparam int HALF  = 10;
    localparam int NP    = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_good = 1'b0;
    logic       vsec_hi = 1'b0;
    logic [1:0] chan_en = 2'b00;
    logic       discon_en = 1'b0;
    logic       scl_dev = 1'b1;
    logic       sda_dev = 1'b1;
    logic [1:0] chan_conn;
    logic       fault, scl_pd, sda_pd;
    logic       scl_in, sda_in;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // Bench-side bus model and monitor state.
    int  rel_at = 0;
    bit  rel_q = 0;
    bit  mon_clr = 0;
    int  pulse_cnt = 0;
    int  stop_cnt = 0;
    logic scl_pd_p = 0, sda_pd_p = 0;

    always #2 clk = ~clk;

    assign scl_in = scl_dev & ~scl_pd;
    assign sda_in = (sda_dev | rel_q) & ~sda_pd;

    busclear_ctrl #(
        .NCH(2), .LOCK_CYC(LOCK), .STUCK_CYC(STUCK),
        .WAIT_CYC(WAITC), .HALF_CYC(HALF), .NPULSE(NP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .vsec_hi(vsec_hi),
        .chan_en(chan_en), .discon_en(discon_en), .scl_in(scl_in), .sda_in(sda_in),
        .chan_conn(chan_conn), .fault(fault), .scl_pd(scl_pd), .sda_pd(sda_pd)
    );

    // Counts pulses and stops on the pulldowns; releases the stuck device.
    always @(negedge clk) begin
        if (mon_clr) begin
            pulse_cnt <= 0;
            stop_cnt  <= 0;
            rel_q     <= 1'b0;
        end else begin
            if (scl_pd && !scl_pd_p && !sda_pd) pulse_cnt <= pulse_cnt + 1;
            if (!sda_pd && sda_pd_p && !scl_pd) stop_cnt <= stop_cnt + 1;
            if (!scl_pd && scl_pd_p && !sda_pd && rel_at != 0 && pulse_cnt >= rel_at)
                rel_q <= 1'b1;
        end
        scl_pd_p <= scl_pd;
        sda_pd_p <= sda_pd;
    end

    function automatic logic [1:0] exp_conn(input logic [1:0] en, input bit lock, input bit link);
        return (lock || !link) ? 2'b00 : en;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        mon_clr = 1; step(1); mon_clr = 0;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int seed_tap;
        int waited;
        seed_tap = $urandom(32'd4312);
        step(4);
        rst_n = 1'b1;
        step(1);
        // Reset state
        check("R1 reset conn", chan_conn, 0);
        check("R1 reset fault", fault, 0);
        check("R11 reset pulldowns", {scl_pd, sda_pd}, 0);

        // R1: enables ignored during power-up lockout
        chan_en = 2'b11;
        step(5);
        check("R1 en ignored while power low", chan_conn, 0);
        pwr_good = 1'b1;
        step(LOCK - 5);
        check("R1 lockout holds", chan_conn, exp_conn(2'b11, 1, 1));
        step(10);
        check("R1 connect after lockout", chan_conn, exp_conn(2'b11, 0, 1));

        // R3: random enables, bus idle high
        for (int i = 0; i < 40; i++) begin
            chan_en = 2'($urandom);
            step(1 + ($urandom % 4));
            check("R3 conn follows en", chan_conn, exp_conn(chan_en, 0, 1));
        end

        // R2: both directions of the supply flag restart the lockout
        chan_en = 2'b11;
        vsec_hi = 1'b1;
        step(2);
        check("R2 rising edge locks", chan_conn, 0);
        for (int i = 0; i < 5; i++) begin
            chan_en = 2'($urandom);
            step(3);
            check("R2 en ignored in lockout", chan_conn, 0);
        end
        chan_en = 2'b11;
        step(LOCK + 5);
        check("R2 reconnect after lockout", chan_conn, 2'b11);
        vsec_hi = 1'b0;
        step(2);
        check("R2 falling edge locks", chan_conn, 0);
        step(LOCK + 5);
        check("R2 reconnect after falling", chan_conn, 2'b11);

        // R4: no monitoring while nothing is connected
        chan_en = 2'b00;
        sda_dev = 1'b0;
        step(2 * STUCK);
        check("R4 no fault when unconnected", fault, 0);
        // R4: a joint high sample restarts the count
        chan_en = 2'b01;
        step(STUCK - 100);
        sda_dev = 1'b1;
        step(4);
        sda_dev = 1'b0;
        step(STUCK - 100);
        check("R4 high sample restarts count", fault, 0);
        sda_dev = 1'b1;
        chan_en = 2'b00;
        step(3);

        // R4/R8: strap low, fault flag only
        discon_en = 1'b0;
        chan_en = 2'b11;
        step(2);
        sda_dev = 1'b0;
        step(STUCK - 10);
        check("R4 no fault before timeout", fault, 0);
        step(20);
        check("R4 fault at timeout", fault, 1);
        check("R8 links kept", chan_conn, 2'b11);
        check("R8 no pulldown", {scl_pd, sda_pd}, 0);
        step(100);
        check("R8 still no pulldown", {scl_pd, sda_pd}, 0);
        sda_dev = 1'b1;
        step(5);
        check("R9 fault held with en high", fault, 1);
        chan_en = 2'b00;
        step(3);
        check("R9 fault cleared", fault, 0);
        chan_en = 2'b10;
        step(1);
        check("R9 reconnect on enable", chan_conn, 2'b10);

        // R5/R6: strap high, full pulse train
        discon_en = 1'b1;
        chan_en = 2'b11;
        clear_mon();
        sda_dev = 1'b0;
        step(STUCK - 10);
        waited = 0;
        while (!fault && waited < 40) begin step(1); waited++; end
        check("R5 fault raised", fault, 1);
        check("R5 links dropped", chan_conn, 0);
        step(WAITC - 5);
        check("R6 quiet wait", pulse_cnt, 0);
        check("R6 no pulldown during wait", scl_pd, 0);
        step(NP * 2 * HALF + 2 * HALF + 30);
        check("R6 pulse count", pulse_cnt, NP);
        check("R6 stop issued", stop_cnt, 1);
        check("R6 pulldowns off after stop", {scl_pd, sda_pd}, 0);
        check("R9 fault held while stuck", fault, 1);
        sda_dev = 1'b1;
        step(5);
        check("R9 fault held until en low", fault, 1);
        check("R9 no link during fault", chan_conn, 0);
        chan_en = 2'b00;
        step(3);
        check("R9 fault clears", fault, 0);
        chan_en = 2'b11;
        step(1);
        check("R9 reconnect", chan_conn, 2'b11);

        // R7: device frees the bus after 3 pulses
        clear_mon();
        rel_at = 3;
        sda_dev = 1'b0;
        step(STUCK + 30 + WAITC + 8 * HALF + 4 * HALF + 30);
        check("R7 early stop pulse count", pulse_cnt, 3);
        check("R7 stop issued", stop_cnt, 1);
        check("R7 fault held", fault, 1);
        chan_en = 2'b00;
        step(3);
        check("R7 fault clears after release", fault, 0);
        rel_at = 0;
        sda_dev = 1'b1;
        clear_mon();

        // R10: power up into a stuck bus
        discon_en = 1'b0;
        pwr_good = 1'b0;
        step(3);
        sda_dev = 1'b0;
        chan_en = 2'b01;
        pwr_good = 1'b1;
        step(LOCK + 5);
        check("R10 connect after lockout", chan_conn, 2'b01);
        check("R10 no fault yet", fault, 0);
        step(STUCK + 10);
        check("R10 fault after timeout", fault, 1);
        // R1: losing power clears the fault and links
        pwr_good = 1'b0;
        step(2);
        check("R1 fault low in lockout", fault, 0);
        check("R1 links off in lockout", chan_conn, 0);
        sda_dev = 1'b1;
        pwr_good = 1'b1;
        step(LOCK + 5);
        check("R3 links after recovery", chan_conn, 2'b01);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule